// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Logic

This block is the device-side control and compare logic of a DRAM model with an 8-bit data path, reduced to a small synchronous cell array. The active-low row strobe, column strobe and write strobe are sampled on a system clock. The block decodes from the order of their edges which kind of cycle is in progress: a normal access, a refresh with the column strobe asserted first, or a row-only refresh. A refresh with the column strobe first and the write strobe low places the device in a latched parallel test mode. In this mode every data line is served by two cells. The two cells of a pair differ only in the top address bit (bit 9), and that bit is not decoded as a column select while the mode is active.

In test mode a write stores the same byte into both cells of the addressed pair. A read returns a per-line pass/fail level instead of data: the line is high when the two cells agree and low when they differ. Test-mode reads take one extra clock before the output is driven. Test mode is left by a row-only refresh, or by a refresh with the column strobe first while the write strobe is high. Normal accesses leave the mode untouched.

Top module: `dram_par_test`

## Requirements
- R1: After reset, `test_mode_o` is 0 and `dq_oe_o` is 0.
- R2: A row-strobe fall sampled while column strobe and write strobe are both low sets `test_mode_o` from the next cycle.
- R3: `test_mode_o` changes only at a clock edge where the sampled row strobe differs from its previous sample. Normal read and write cycles never change it.
- R4: A row-strobe fall sampled while the column strobe is low and the write strobe is high clears `test_mode_o` from the next cycle.
- R5: A row cycle opened with the column strobe high and closed without any column-strobe fall is a row-only refresh. It clears `test_mode_o` from the cycle after the row-strobe rise is sampled.
- R6: In normal mode, a column-strobe fall inside an open row accesses one byte. The cell is selected by the row (address bits 1:0 at the row-strobe fall), the column (address bits 2:0) and the pair bit (address bit 9). Write strobe low means write `dq_i`; write strobe high means read, and a read drives `dq_oe_o` and the stored byte on `dq_o` from the cycle after the fall.
- R7: In test mode, a write stores `dq_i` into both cells of the pair, whatever the value of address bit 9.
- R8: In test mode, a read gives, for each bit, `dq_o` = 1 if the two cells of the pair hold equal bits and 0 if they differ, independent of address bit 9.
- R9: A test-mode read drives `dq_oe_o` one cycle later than a normal read, that is, two cycles after the column-strobe fall.
- R10: `dq_oe_o` is 0 in the cycle after any clock edge at which the column strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| addr_i | input | 10 | Multiplexed row/column address |
| dq_i | input | 8 | Write data |
| dq_o | output | 8 | Read data or per-line compare result |
| dq_oe_o | output | 1 | Read output valid |
| test_mode_o | output | 1 | Parallel test mode is latched |

## Verification
A wrong mode latch shows up at once on `test_mode_o`, one cycle after the deciding row-strobe edge. It also changes the output timing of the very next read, which arrives one cycle early or late, and turns stored data into compare levels or the reverse. A write that fills only one cell of a pair in test mode stays hidden until that pair is read. A following test-mode read then returns 0 bits where the old contents of the other cell differ. A normal read of the other half, after a row-only refresh exit, returns stale data. The bench therefore fills every cell first, so that each later read gives the fault a known value to show against.

// File: rtl/dram_par_test_pkg.sv
package dram_par_test_pkg;
  typedef enum logic [1:0] {
    RK_IDLE    = 2'd0,
    RK_ACCESS  = 2'd1,
    RK_REFRESH = 2'd2
  } ras_kind_e;

  typedef struct packed {
    logic enter;
    logic leave;
  } mode_cmd_t;
endpackage

// File: rtl/dram_par_test_strobe.sv
module dram_par_test_strobe
  import dram_par_test_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ras_n_i,
  input  logic      cas_n_i,
  input  logic      we_n_i,
  output mode_cmd_t cmd_o,
  output logic      row_ld_o,
  output logic      acc_o,
  output logic      acc_wr_o
);
  logic      ras_q, cas_q, cas_seen_q;
  ras_kind_e kind_q;
  logic      ras_fall, ras_rise, cas_fall;

  assign ras_fall = ras_q & ~ras_n_i;
  assign ras_rise = ~ras_q & ras_n_i;
  assign cas_fall = cas_q & ~cas_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      cas_seen_q <= 1'b0;
      kind_q     <= RK_IDLE;
    end else begin
      ras_q <= ras_n_i;
      cas_q <= cas_n_i;
      if (ras_fall) begin
        kind_q     <= cas_n_i ? RK_ACCESS : RK_REFRESH;
        cas_seen_q <= 1'b0;
      end else if (ras_rise) begin
        kind_q <= RK_IDLE;
      end else if (acc_o) begin
        cas_seen_q <= 1'b1;
      end
    end
  end

  // column strobe first at row fall: refresh, write strobe picks enter or leave
  always_comb begin
    cmd_o.enter = ras_fall & ~cas_n_i & ~we_n_i;
    cmd_o.leave = (ras_fall & ~cas_n_i & we_n_i) |
                  (ras_rise & (kind_q == RK_ACCESS) & ~cas_seen_q);
  end

  assign row_ld_o = ras_fall & cas_n_i;
  assign acc_o    = cas_fall & ~ras_n_i & ~ras_fall & (kind_q == RK_ACCESS);
  assign acc_wr_o = ~we_n_i;
endmodule

// File: rtl/dram_par_test_mode.sv
module dram_par_test_mode
  import dram_par_test_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  mode_cmd_t cmd_i,
  output logic      test_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          test_o <= 1'b0;
    else if (cmd_i.enter) test_o <= 1'b1;
    else if (cmd_i.leave) test_o <= 1'b0;
  end
endmodule

// File: rtl/dram_par_test_array.sv
module dram_par_test_array #(
  parameter int IDX_W = 5,
  parameter int DQ_W  = 8
) (
  input  logic                 clk_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [1:0]           wen_i,
  input  logic                 ren_i,
  input  logic [DQ_W-1:0]      wdata_i,
  output logic [1:0][DQ_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DQ_W-1:0] mem [DEPTH];
    logic [DQ_W-1:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (wen_i[h]) mem[idx_i] <= wdata_i;
      if (ren_i)    rd_q       <= mem[idx_i];
    end
    assign rdata_o[h] = rd_q;
  end
endmodule

// File: rtl/dram_par_test_rdpath.sv
module dram_par_test_rdpath #(
  parameter int DQ_W      = 8,
  parameter int TEST_XLAT = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 test_i,
  input  logic                 sel_i,
  input  logic                 cas_n_i,
  input  logic [1:0][DQ_W-1:0] cells_i,
  output logic [DQ_W-1:0]      dq_o,
  output logic                 oe_o
);
  localparam int WW = $clog2(TEST_XLAT + 2);
  localparam logic [WW-1:0] XLAT = WW'(TEST_XLAT);

  logic          act_q, test_q, sel_q;
  logic [WW-1:0] wait_q;
  logic [DQ_W-1:0] res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      test_q <= 1'b0;
      sel_q  <= 1'b0;
      wait_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      test_q <= test_i;
      sel_q  <= sel_i;
      wait_q <= test_i ? XLAT : '0;
    end else if (cas_n_i) begin
      act_q  <= 1'b0;
      wait_q <= '0;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  // test read: 1 where both cells agree
  assign res  = test_q ? ~(cells_i[0] ^ cells_i[1]) : cells_i[sel_q];
  assign oe_o = act_q & (wait_q == '0);
  assign dq_o = oe_o ? res : '0;
endmodule

// File: rtl/dram_par_test.sv
module dram_par_test #(
  parameter int ADDR_W    = 10,
  parameter int DQ_W      = 8,
  parameter int ROW_W     = 2,
  parameter int COLLO_W   = 3,
  parameter int TEST_XLAT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              test_mode_o
);
  import dram_par_test_pkg::*;

  localparam int IDX_W    = ROW_W + COLLO_W;
  localparam int PAIR_BIT = ADDR_W - 1;

  mode_cmd_t               cmd;
  logic                    row_ld, acc, acc_wr;
  logic [ROW_W-1:0]        row_q;
  logic [IDX_W-1:0]        idx;
  logic                    pb;
  logic [1:0]              wen;
  logic                    ren;
  logic [1:0][DQ_W-1:0]    cells;

  dram_par_test_strobe u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .cmd_o   (cmd),
    .row_ld_o(row_ld),
    .acc_o   (acc),
    .acc_wr_o(acc_wr)
  );

  dram_par_test_mode u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd),
    .test_o(test_mode_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (row_ld) row_q <= addr_i[ROW_W-1:0];
  end

  assign idx = {row_q, addr_i[COLLO_W-1:0]};
  assign pb  = addr_i[PAIR_BIT];
  assign ren = acc & ~acc_wr;

  always_comb begin
    wen = 2'b00;
    if (acc & acc_wr) begin
      if (test_mode_o) wen = 2'b11;
      else             wen = pb ? 2'b10 : 2'b01;
    end
  end

  dram_par_test_array #(.IDX_W(IDX_W), .DQ_W(DQ_W)) u_array (
    .clk_i  (clk_i),
    .idx_i  (idx),
    .wen_i  (wen),
    .ren_i  (ren),
    .wdata_i(dq_i),
    .rdata_o(cells)
  );

  dram_par_test_rdpath #(.DQ_W(DQ_W), .TEST_XLAT(TEST_XLAT)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ren),
    .test_i (test_mode_o),
    .sel_i  (pb),
    .cas_n_i(cas_n_i),
    .cells_i(cells),
    .dq_o   (dq_o),
    .oe_o   (dq_oe_o)
  );
endmodule

// File: rtl/dram_par_test_chk.sv
module dram_par_test_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_n_i,
  input logic cas_n_i,
  input logic we_n_i,
  input logic dq_oe_o,
  input logic test_mode_o
);
  p_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_i) && !cas_n_i && !we_n_i) |=> test_mode_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(ras_n_i) |=> $stable(test_mode_o));

  p_cbr_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_i) && !cas_n_i && we_n_i) |=> !test_mode_o);

  p_slow_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_o && $fell(cas_n_i)) |=> !dq_oe_o);

  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_n_i |=> !dq_oe_o);
endmodule

bind dram_par_test dram_par_test_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_n_i    (ras_n_i),
  .cas_n_i    (cas_n_i),
  .we_n_i     (we_n_i),
  .dq_oe_o    (dq_oe_o),
  .test_mode_o(test_mode_o)
);

// File: tb/sim_dram_par_test.sv
module sim_dram_par_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic       oe, tm;

  int total = 0, bad = 0;
  logic [7:0] m0 [32];
  logic [7:0] m1 [32];
  bit tm_exp = 1'b0;

  always #2 clk = ~clk;

  dram_par_test u0 (
    .clk_i(clk), .rst_ni(rst_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out),
    .dq_oe_o(oe), .test_mode_o(tm)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(int i, bit pb, bit t);
    if (t) return ~(m0[i] ^ m1[i]);
    return pb ? m1[i] : m0[i];
  endfunction

  task automatic open_row(int r);
    addr = 10'(r); ras_n = 1'b0; step();
  endtask

  task automatic close_row();
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; step(); step();
  endtask

  task automatic wr(int r, int c, bit pb, logic [7:0] d);
    int i = r * 8 + c;
    addr = {pb, 6'b0, 3'(c)}; dq_in = d; we_n = 1'b0; cas_n = 1'b0; step();
    cas_n = 1'b1; we_n = 1'b1; step();
    if (tm_exp) begin m0[i] = d; m1[i] = d; end
    else if (pb) m1[i] = d;
    else m0[i] = d;
  endtask

  task automatic rd(int r, int c, bit pb);
    int i = r * 8 + c;
    addr = {pb, 6'b0, 3'(c)}; we_n = 1'b1; cas_n = 1'b0; step();
    if (tm_exp) begin
      chk("R9 test read not yet driven", 32'(oe), 32'd0);
      step();
    end
    chk(tm_exp ? "R9 test read oe" : "R6 read oe", 32'(oe), 32'd1);
    chk(tm_exp ? "R8 compare data" : "R6 read data", 32'(dq_out), 32'(exp_rd(i, pb, tm_exp)));
    cas_n = 1'b1; step();
    chk("R10 oe released", 32'(oe), 32'd0);
  endtask

  task automatic cbr(bit w);
    cas_n = 1'b0; we_n = w; step();
    ras_n = 1'b0; step();
    tm_exp = !w;
    chk(w ? "R4 cbr exit" : "R2 cbr enter", 32'(tm), 32'(tm_exp));
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step(); step();
  endtask

  task automatic ras_only(int r);
    open_row(r); step();
    ras_n = 1'b1; step();
    tm_exp = 1'b0;
    chk("R5 ras-only exit", 32'(tm), 32'd0);
    step();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    chk("R1 reset test mode", 32'(tm), 32'd0);
    chk("R1 reset oe", 32'(oe), 32'd0);
    rst_n = 1'b1; step();

    // fill every cell in normal mode
    for (int r = 0; r < 4; r++) begin
      open_row(r);
      for (int c = 0; c < 8; c++) begin
        wr(r, c, 1'b0, 8'($urandom));
        wr(r, c, 1'b1, 8'($urandom));
      end
      close_row();
    end
    chk("R3 normal writes keep mode", 32'(tm), 32'd0);

    // directed corners
    open_row(1); wr(1, 2, 1'b0, 8'hA5); wr(1, 2, 1'b1, 8'h5A);
    rd(1, 2, 1'b0); rd(1, 2, 1'b1); close_row();

    cbr(1'b0);
    open_row(1); rd(1, 2, 1'b0); rd(1, 2, 1'b1);
    wr(1, 3, 1'b1, 8'h3C); rd(1, 3, 1'b0); close_row();
    chk("R3 mode kept after access", 32'(tm), 32'd1);
    open_row(2); wr(2, 5, 1'b0, 8'hF0); close_row();
    chk("R5 write-only row keeps mode", 32'(tm), 32'd1);

    ras_only(0);
    open_row(1); rd(1, 3, 1'b0); rd(1, 3, 1'b1); close_row();
    chk("R7 both halves written", 32'(m0[11] == 8'h3C && m1[11] == 8'h3C), 32'd1);
    open_row(2); rd(2, 5, 1'b0); rd(2, 5, 1'b1); close_row();

    cbr(1'b0);
    cbr(1'b1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom % 10);
      int r  = int'($urandom % 4);
      if (op == 0) cbr(1'b0);
      else if (op == 1) begin if (tm_exp) cbr(1'b1); end
      else if (op == 2) ras_only(r);
      else begin
        open_row(r);
        for (int k = 0; k < 3; k++) begin
          int  c  = int'($urandom % 8);
          bit  pb = 1'($urandom);
          if ($urandom % 2) wr(r, c, pb, 8'($urandom));
          else rd(r, c, pb);
        end
        close_row();
        chk("R3 random access keeps mode", 32'(tm), 32'(tm_exp));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule